// File: doc/BRIEF.md
# Zero-Suppressed Waveform Recorder with Rollover Records

The recorder accepts a stream of 8-bit samples with one discriminator bit per sample. It packs every eight consecutive accepted samples into a 64-bit record. A record is written to an external buffer memory only if at least one of its samples lies in an active window. A sample is in an active window if the discriminator is high on it, if it falls within a programmable tail after the discriminator drops, if it falls within a fixed span before the discriminator rises, or if zero suppression is switched off for that sample. Groups in which no sample is active are dropped.

A free-running time counter advances on every clock whether or not samples arrive. Whenever it reaches its all-ones value, the recorder writes a rollover record, so that software can count counter wraps and rebuild absolute time from the buffer. Rollover is detected one cycle early from a registered compare, so the timeword is captured in the cycle the counter actually holds all-ones. Each memory entry carries a one-bit kind flag beside the 64-bit record, so a rollover record can never be mistaken for sample data. The write pointer counts from zero. After it passes the last entry it wraps to zero and a sticky full flag stops all recording.

The sample input is a valid/ready stream. A sample moves on a cycle where `s_valid` and `s_ready` are both high. `s_ready` is high at all times except once the buffer is full; from then on it stays low until reset. The memory side is a plain write port that never stalls: at most one write per cycle.

Top module: `zs_wave_recorder`

## Requirements
- R1: The time counter starts at 0 after reset and increments every clock. In the cycle after each cycle in which it holds all-ones, a rollover record is written, even with no samples arriving. The one exception is when R8 delays it by a cycle.
- R2: A rollover record has `mem_kind`=1, bits [7:0]=0xA5, bits [8+:TW] equal to the all-ones timeword captured in the detection cycle, and zero in all higher bits.
- R3: A signal record has `mem_kind`=0 and holds eight consecutive accepted samples, the earliest in bits [7:0] and each later sample one byte higher. It is written in the cycle after the accepted sample that completes the following group of eight.
- R4: A group is written if and only if at least one of its samples is active; groups with no active sample produce no write.
- R5: A sample is active if the discriminator is high on any of the next PRE_N accepted samples (pre-samples, 1 ≤ PRE_N ≤ 8).
- R6: A sample is active if it is the k-th accepted sample after the most recent discriminator-high sample and k ≤ `post_len`, using the `post_len` value present on that discriminator-high sample.
- R7: A sample accepted while `sup_off` is high is active, whatever the discriminator does.
- R8: If a signal record and a rollover record are due in the same cycle, the signal record is written first and the rollover record in the next cycle, at consecutive addresses.
- R9: Writes use consecutive addresses starting at 0 after reset. After address DEPTH-1 is written the pointer wraps to 0 and `full` rises.
- R10: While `full` is high, `s_ready` is low and no writes occur. `full` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready; low only while full |
| s_sample | input | 8 | Sample value |
| s_disc | input | 1 | Discriminator bit for this sample |
| sup_off | input | 1 | High disables zero suppression for this sample |
| post_len | input | PW | Tail length in samples after a discriminator-high sample |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | AW | Buffer write address |
| mem_data | output | 64 | Record written |
| mem_kind | output | 1 | 1 for rollover record, 0 for signal record |
| full | output | 1 | Sticky buffer-full flag |

## Verification
The hardest situation to reach is the collision: a group must complete on exactly the clock edge at which the counter holds all-ones, while the held group is active. The bench tracks the counter in its own model. It waits for a cycle whose count is a multiple of eight at a group boundary, then streams discriminator-high samples without a gap for more than one counter period. Some group completion must then land on the all-ones count. The bench confirms this from its model and also sees a signal write followed directly by a rollover write at consecutive addresses. The pre-sample and tail windows are driven at hand-picked positions inside groups, so that the expected record counts are known without the model.

// File: rtl/zsr_pkg.sv
package zsr_pkg;
  localparam int SMP_W  = 8;
  localparam int GRP_N  = 8;
  localparam int IDX_W  = $clog2(GRP_N);
  localparam int REC_W  = SMP_W * GRP_N;
  localparam int TWX_W  = REC_W - SMP_W;
  localparam logic [SMP_W-1:0] ROLL_TAG = 8'hA5;

  // Rollover record: tag in the low byte, zero-extended timeword above it.
  function automatic logic [REC_W-1:0] roll_record(input logic [TWX_W-1:0] tw_ext);
    return {tw_ext, ROLL_TAG};
  endfunction
endpackage

// File: rtl/zsr_timebase.sv
module zsr_timebase #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] tcnt,
  output logic          roll_due
);
  localparam logic [TW-1:0] TMAX = '1;
  localparam logic [TW-1:0] TPRE = TMAX - 1'b1;

  logic [TW-1:0] tcnt_q;
  logic          due_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      due_q  <= 1'b0;
    end else begin
      tcnt_q <= tcnt_q + 1'b1;
      due_q  <= (tcnt_q == TPRE);
    end
  end

  assign tcnt     = tcnt_q;
  assign roll_due = due_q;

  // R1: the early registered compare lands exactly on the all-ones count
  a_r1_roll_align: assert property (@(posedge clk) disable iff (!rst_n)
    roll_due |-> (tcnt == TMAX));
endmodule

// File: rtl/zsr_window.sv
module zsr_window #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          disc,
  input  logic          sup,
  input  logic [PW-1:0] post_len,
  output logic          active
);
  logic [PW-1:0] tail_q;
  logic          tail_on;

  assign tail_on = (tail_q != '0);
  assign active  = disc | sup | tail_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
    end else if (accept) begin
      if (disc)         tail_q <= post_len;
      else if (tail_on) tail_q <= tail_q - 1'b1;
    end
  end
endmodule

// File: rtl/zsr_packer.sv
module zsr_packer
  import zsr_pkg::*;
#(
  parameter int PRE_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [SMP_W-1:0] sample,
  input  logic             disc,
  input  logic             active,
  output logic             sig_fire,
  output logic [REC_W-1:0] sig_data
);
  localparam logic [IDX_W:0] PRE_LIM = (IDX_W+1)'(PRE_N);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GRP_N - 1);

  logic [REC_W-1:0] cur_q, cur_next, held_q;
  logic [IDX_W-1:0] idx_q;
  logic             cur_keep_q, pre_hit_q, held_keep_q, held_vld_q;
  logic             keep_now, pre_now, last;

  always_comb begin
    cur_next = cur_q;
    cur_next[{idx_q, 3'b000} +: SMP_W] = sample;
  end

  assign keep_now = cur_keep_q | active;
  assign pre_now  = pre_hit_q | (disc & ({1'b0, idx_q} < PRE_LIM));
  assign last     = accept & (idx_q == LAST_IDX);
  // The held group is decided once the following group is complete.
  assign sig_fire = last & held_vld_q & (held_keep_q | pre_now);
  assign sig_data = held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q       <= '0;
      held_q      <= '0;
      idx_q       <= '0;
      cur_keep_q  <= 1'b0;
      pre_hit_q   <= 1'b0;
      held_keep_q <= 1'b0;
      held_vld_q  <= 1'b0;
    end else if (accept) begin
      cur_q <= cur_next;
      idx_q <= idx_q + 1'b1;
      if (last) begin
        held_q      <= cur_next;
        held_keep_q <= keep_now;
        held_vld_q  <= 1'b1;
        cur_keep_q  <= 1'b0;
        pre_hit_q   <= 1'b0;
      end else begin
        cur_keep_q  <= keep_now;
        pre_hit_q   <= pre_now;
      end
    end
  end
endmodule

// File: rtl/zsr_writer.sv
module zsr_writer
  import zsr_pkg::*;
#(
  parameter int AW = 16,
  parameter int TW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_fire,
  input  logic [REC_W-1:0] sig_data,
  input  logic             roll_due,
  input  logic [TW-1:0]    tcnt,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [REC_W-1:0] mem_data,
  output logic             mem_kind,
  output logic             full
);
  localparam logic [AW-1:0] LAST_ADDR = '1;

  logic [AW-1:0]    ptr_q, addr_q;
  logic [REC_W-1:0] data_q, nxt_data;
  logic [TW-1:0]    pend_tw_q;
  logic             we_q, kind_q, full_q, pend_q;
  logic             nxt_we, nxt_kind, set_pend, clr_pend;

  always_comb begin
    nxt_we   = 1'b0;
    nxt_kind = kind_q;
    nxt_data = data_q;
    set_pend = 1'b0;
    clr_pend = 1'b0;
    if (!full_q) begin
      if (sig_fire) begin
        nxt_we   = 1'b1;
        nxt_kind = 1'b0;
        nxt_data = sig_data;
        set_pend = roll_due;
      end else if (pend_q) begin
        nxt_we   = 1'b1;
        nxt_kind = 1'b1;
        nxt_data = roll_record({{(TWX_W-TW){1'b0}}, pend_tw_q});
        clr_pend = 1'b1;
      end else if (roll_due) begin
        nxt_we   = 1'b1;
        nxt_kind = 1'b1;
        nxt_data = roll_record({{(TWX_W-TW){1'b0}}, tcnt});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      pend_tw_q <= '0;
      we_q      <= 1'b0;
      kind_q    <= 1'b0;
      full_q    <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      we_q <= nxt_we;
      if (set_pend) begin
        pend_q    <= 1'b1;
        pend_tw_q <= tcnt;
      end else if (clr_pend) begin
        pend_q    <= 1'b0;
      end
      if (nxt_we) begin
        data_q <= nxt_data;
        kind_q <= nxt_kind;
        addr_q <= ptr_q;
        ptr_q  <= ptr_q + 1'b1;
        if (ptr_q == LAST_ADDR) full_q <= 1'b1;
      end
    end
  end

  assign mem_we   = we_q;
  assign mem_addr = addr_q;
  assign mem_data = data_q;
  assign mem_kind = kind_q;
  assign full     = full_q;

  // R8: a deferred rollover record never meets a second signal record
  a_r8_pend_no_signal: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !sig_fire);
  // R2: every rollover record carries the tag and the all-ones timeword
  a_r2_roll_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_kind) |-> (mem_data[SMP_W +: TW] == {TW{1'b1}} &&
                              mem_data[SMP_W-1:0] == ROLL_TAG));
  // R10: nothing is written once the buffer is full
  a_r10_quiet_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> !mem_we);
endmodule

// File: rtl/zs_wave_recorder.sv
module zs_wave_recorder
  import zsr_pkg::*;
#(
  parameter int TW    = 16,
  parameter int AW    = 16,
  parameter int PRE_N = 4,
  parameter int PW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [SMP_W-1:0] s_sample,
  input  logic             s_disc,
  input  logic             sup_off,
  input  logic [PW-1:0]    post_len,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [REC_W-1:0] mem_data,
  output logic             mem_kind,
  output logic             full
);
  logic [TW-1:0]    tcnt;
  logic             roll_due, accept, active, sig_fire;
  logic [REC_W-1:0] sig_data;

  assign s_ready = !full;
  assign accept  = s_valid & s_ready;

  zsr_timebase #(.TW(TW)) u_time (
    .clk(clk), .rst_n(rst_n), .tcnt(tcnt), .roll_due(roll_due));

  zsr_window #(.PW(PW)) u_win (
    .clk(clk), .rst_n(rst_n), .accept(accept), .disc(s_disc),
    .sup(sup_off), .post_len(post_len), .active(active));

  zsr_packer #(.PRE_N(PRE_N)) u_pack (
    .clk(clk), .rst_n(rst_n), .accept(accept), .sample(s_sample),
    .disc(s_disc), .active(active), .sig_fire(sig_fire), .sig_data(sig_data));

  zsr_writer #(.AW(AW), .TW(TW)) u_wr (
    .clk(clk), .rst_n(rst_n), .sig_fire(sig_fire), .sig_data(sig_data),
    .roll_due(roll_due), .tcnt(tcnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_kind(mem_kind), .full(full));
endmodule

// File: tb/zs_wave_recorder_tb_top.sv
module zs_wave_recorder_tb_top;
  localparam int TW = 8, AW = 7, PRE_N = 3, PW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int TMAX  = (1 << TW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, s_valid = 1'b0, s_disc = 1'b0, sup_off = 1'b0;
  logic [7:0] s_sample = '0;
  logic [PW-1:0] post_len = '0;
  logic s_ready, mem_we, mem_kind, full;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_data;

  zs_wave_recorder #(.TW(TW), .AW(AW), .PRE_N(PRE_N), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_sample(s_sample), .s_disc(s_disc), .sup_off(sup_off), .post_len(post_len),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_kind(mem_kind), .full(full));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit dq[$]; bit sq[$]; int pq[$]; logic [7:0] vq[$];
  int m_t, m_ptr, m_coll;
  bit m_full, m_pend, e_we, e_kind;
  int e_addr;
  logic [63:0] e_data;

  // observed counters
  int n_sig, n_roll, n_pair, after_full;
  int last_addr;
  bit prev_we, prev_kind, prev_full;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit kept(int g);
    for (int i = 8*g; i < 8*g + 8; i++) begin
      if (sq[i] || dq[i]) return 1'b1;
      for (int k = 1; k <= PRE_N; k++)
        if (i + k < dq.size() && dq[i+k]) return 1'b1;
      for (int d = i - 1; d >= 0 && d >= i - 16; d--)
        if (dq[d]) begin
          if (i - d <= pq[d]) return 1'b1;
          break;
        end
    end
    return 1'b0;
  endfunction

  function automatic logic [63:0] grp(int g);
    logic [63:0] r = '0;
    for (int j = 0; j < 8; j++) r[8*j +: 8] = vq[8*g + j];
    return r;
  endfunction

  function automatic logic [63:0] rollrec();
    logic [63:0] r = '0;
    r[7:0] = 8'hA5;
    r[8 +: TW] = '1;
    return r;
  endfunction

  task automatic emit(input logic [63:0] d, input bit k);
    e_we = 1; e_data = d; e_kind = k; e_addr = m_ptr;
    if (m_ptr == DEPTH - 1) m_full = 1;
    m_ptr = (m_ptr + 1) % DEPTH;
  endtask

  always @(posedge clk) begin
    bit sig, rnow;
    int n;
    if (!rst_n) begin
      dq.delete(); sq.delete(); pq.delete(); vq.delete();
      m_t = 0; m_ptr = 0; m_full = 0; m_pend = 0; e_we = 0; m_coll = 0;
    end else begin
      e_we = 0; sig = 0; n = 0;
      if (s_valid && !m_full) begin
        dq.push_back(s_disc); sq.push_back(sup_off);
        pq.push_back(int'(post_len)); vq.push_back(s_sample);
        n = vq.size();
        if (n % 8 == 0 && n >= 16 && kept(n/8 - 2)) sig = 1;
      end
      rnow = (m_t == TMAX);
      if (!m_full) begin
        if (sig) begin
          emit(grp(n/8 - 2), 0);
          if (rnow) begin m_pend = 1; m_coll++; end
        end else if (m_pend) begin
          emit(rollrec(), 1); m_pend = 0;
        end else if (rnow) emit(rollrec(), 1);
      end
      m_t = (m_t + 1) % (TMAX + 1);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(mem_we === e_we, "R4 write strobe", 64'(mem_we), 64'(e_we));
      if (e_we && mem_we) begin
        check(mem_addr === AW'(e_addr), "R9 address", 64'(mem_addr), 64'(e_addr));
        check(mem_kind === e_kind, e_kind ? "R2 kind" : "R3 kind",
              64'(mem_kind), 64'(e_kind));
        check(mem_data === e_data, e_kind ? "R2 rollover data" : "R3 signal data",
              mem_data, e_data);
      end
      check(full === m_full, "R10 full", 64'(full), 64'(m_full));
      check(s_ready === !m_full, "R10 s_ready", 64'(s_ready), 64'(!m_full));
      if (mem_we) begin
        if (mem_kind) n_roll++; else n_sig++;
        if (prev_we && !prev_kind && mem_kind) n_pair++;
        last_addr = int'(mem_addr);
        if (prev_full) after_full++;
      end
      prev_we = mem_we; prev_kind = mem_kind; prev_full = full;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R4 watchdog act=%0d exp=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int base;
  task automatic send(input logic [7:0] d, input bit disc, input bit sup);
    s_valid = 1; s_sample = d; s_disc = disc; sup_off = sup;
    @(negedge clk);
    s_valid = 0; s_disc = 0; sup_off = 0;
  endtask

  task automatic send_grp(input int disc_pos, input int sup_pos);
    for (int j = 0; j < 8; j++) begin
      send(8'(base), j == disc_pos, j == sup_pos);
      base++;
    end
  endtask

  initial begin
    int s0, r0, cnt;
    base = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(s_ready === 1'b1, "R10 reset ready", 64'(s_ready), 64'd1);
    check(full === 1'b0, "R9 reset full", 64'(full), 64'd0);
    check(mem_we === 1'b0, "R9 reset write", 64'(mem_we), 64'd0);

    // quiet groups and bare rollovers
    s0 = n_sig; r0 = n_roll;
    for (int g = 0; g < 4; g++) send_grp(-1, -1);
    repeat (512) @(negedge clk);
    check(n_sig == s0, "R4 quiet groups", 64'(n_sig - s0), 64'(0));
    check(n_roll - r0 == 2, "R1 idle rollovers", 64'(n_roll - r0), 64'd2);

    // pre-samples: discriminator at position 1 reaches back into the previous group
    s0 = n_sig;
    send_grp(-1, -1); send_grp(1, -1); send_grp(-1, -1); send_grp(-1, -1);
    @(negedge clk);
    check(n_sig - s0 == 2, "R5 pre window spans groups", 64'(n_sig - s0), 64'd2);
    // position 5 is beyond the pre window of the previous group
    s0 = n_sig;
    send_grp(-1, -1); send_grp(5, -1); send_grp(-1, -1); send_grp(-1, -1);
    @(negedge clk);
    check(n_sig - s0 == 1, "R5 pre window limit", 64'(n_sig - s0), 64'd1);

    // tail of 10 samples after a discriminator at the last position
    post_len = 4'd10;
    s0 = n_sig;
    send_grp(7, -1); send_grp(-1, -1); send_grp(-1, -1); send_grp(-1, -1);
    send_grp(-1, -1);
    @(negedge clk);
    check(n_sig - s0 == 3, "R6 post tail", 64'(n_sig - s0), 64'd3);
    post_len = 4'd0;

    // suppression off for a single sample
    s0 = n_sig;
    send_grp(-1, 3); send_grp(-1, -1); send_grp(-1, -1);
    @(negedge clk);
    check(n_sig - s0 == 1, "R7 suppress off", 64'(n_sig - s0), 64'd1);

    // random stream with gaps and a varying tail
    for (int g = 0; g < 24; g++)
      for (int j = 0; j < 8; j++) begin
        post_len = 4'($urandom_range(0, 6));
        while ($urandom_range(0, 3) == 0) @(negedge clk);
        send(8'($urandom), $urandom_range(0, 19) == 0, $urandom_range(0, 49) == 0);
      end
    post_len = 4'd0;

    // collision: group completions aligned to count 7 mod 8
    while (m_t % 8 != 0) @(negedge clk);
    cnt = n_pair;
    for (int i = 0; i < 264; i++) begin send(8'(base), 1, 0); base++; end
    repeat (3) @(negedge clk);
    check(m_coll >= 1, "R8 collision reached", 64'(m_coll), 64'd1);
    check(n_pair > cnt, "R8 signal then rollover", 64'(n_pair - cnt), 64'd1);

    // fill the buffer
    for (int i = 0; i < 3000 && !full; i++) send(8'(i), 0, 1);
    repeat (40) @(negedge clk);
    check(full === 1'b1, "R9 full raised", 64'(full), 64'd1);
    check(last_addr == DEPTH - 1, "R9 last address", 64'(last_addr), 64'(DEPTH - 1));
    check(s_ready === 1'b0, "R10 ready low", 64'(s_ready), 64'd0);
    for (int i = 0; i < 8; i++) send(8'hFF, 1, 1);
    repeat (300) @(negedge clk);
    check(after_full == 0, "R10 no writes when full", 64'(after_full), 64'd0);
    check(full === 1'b1, "R10 full sticky", 64'(full), 64'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule